// File: doc/BRIEF.md
# DMA Block-Move Byte Counter

This block holds the remaining byte count of a DMA block-move operation that runs between system memory and a peripheral bus. An instruction fetch, a block-move start, a table-indirect offset or a host register write can load the 24-bit counter. The source select and the load strobe decide which value is taken. While a block move is armed, each completed bus transfer lowers the count by the number of bytes that transfer carried. Which transfer strobe counts depends on the transfer direction. When sending to the peripheral bus, the count drops as memory data enters the DMA FIFO. When receiving, it drops as data is written out to memory.

A block-move load with a count of zero is invalid and raises a one-cycle illegal-instruction interrupt. The exception is a controller acting as a target during the command phase, where a zero count is legal. A transfer that claims more bytes than remain raises an overrun pulse, and the counter saturates at zero instead of wrapping. A done flag marks an exhausted count.

The control is a three-state machine. ST_IDLE means the register holds data and is not counting. ST_COUNT means a block move is armed. ST_DONE means the count is exhausted. The transitions are:
- T_WRITE: a host write, from any state, to ST_COUNT if the value is nonzero, else to ST_DONE.
- T_ARM: a block-move load, to ST_COUNT if the count is nonzero, else to ST_DONE.
- T_HOLD: a fetch or table load, to ST_IDLE.
- T_STEP: a decrement that leaves a nonzero count, staying in ST_COUNT.
- T_EXHAUST: a decrement that reaches zero exactly, from ST_COUNT to ST_DONE.
- T_OVERRUN: a transfer larger than the remainder, from ST_COUNT to ST_DONE.

Top module: `dma_bytecnt`

## Requirements
- R1: A host write (`host_we`) loads `host_wdata` into the count in any state. It takes priority over a load and over a transfer strobe in the same cycle. A nonzero value arms counting with `done` low. A zero value sets `done` and raises no interrupt.
- R2: A load with `ld_src`=0 (block move) takes `insn_word[23:0]` as the count and arms counting. The bits above 23 are ignored. It takes priority over a transfer strobe in the same cycle. Any value up to 0xFFFFFF loads unchanged.
- R3: While counting, a transfer strobe lowers the count by its byte amount, not by one. With `dir_send`=1 only `fill_vld`/`fill_bytes` count, and with `dir_send`=0 only `wr_vld`/`wr_bytes` count. The other strobe has no effect.
- R4: `done` is high in the first cycle the count shows zero after a decrement. It stays high while no load or write occurs, and transfer strobes leave the count at zero during that time.
- R5: A block-move load of zero raises `illegal_irq` for exactly one cycle, the cycle in which the count shows zero. The exception is when `tgt_mode` and `cmd_phase` are both high during the load, in which case no interrupt is raised. In both cases `done` goes high.
- R6: `ld_src`=1 (instruction fetch) loads `insn_word[23:0]`, and `ld_src`=2 (table-indirect offset) loads `offset_in`. Neither raises an interrupt or arms counting: `done` is low and strobes leave the count unchanged. `ld_src`=3 is reserved, and a load with it leaves the count and flags unchanged.
- R7: A strobe whose byte amount exceeds the remaining count pulses `overrun` for one cycle, sets the count to zero and sets `done`. A byte amount equal to the count reaches zero without `overrun`.
- R8: After reset, `done`, `illegal_irq` and `overrun` are low and the block is idle. The count value is undefined until the first load or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_wdata | input | 24 | Host write value |
| ld_valid | input | 1 | Load strobe from the instruction path |
| ld_src | input | 2 | Load source: 0 block move, 1 fetch, 2 table offset, 3 reserved |
| insn_word | input | 32 | Fetched first instruction word |
| offset_in | input | 24 | Table-indirect offset value |
| dir_send | input | 1 | 1 = sending to peripheral bus, 0 = receiving |
| fill_vld | input | 1 | Memory-to-FIFO transfer completed |
| fill_bytes | input | 4 | Bytes moved by that fill |
| wr_vld | input | 1 | Write-to-memory transfer completed |
| wr_bytes | input | 4 | Bytes moved by that write |
| tgt_mode | input | 1 | Controller acting as target |
| cmd_phase | input | 1 | Bus is in command phase |
| count | output | 24 | Current byte count |
| done | output | 1 | Count exhausted |
| illegal_irq | output | 1 | Zero-count block-move interrupt pulse |
| overrun | output | 1 | Transfer exceeded remaining count |

## Verification
Assertions check the following on every cycle:
- `done`, `illegal_irq` and `overrun` only ever coincide with a zero count.
- An interrupt never follows an exempt load.
- A host write always lands.
- The count stays frozen while idle or done.

Only the bench scenarios can show the remaining behaviour:
- Direction selects the right strobe.
- The byte amount, rather than one, is subtracted.
- Load priority holds over strobes.
- Fetch and table values route correctly, including the masking of the upper instruction bits.
- An exact drain to zero differs from an overrun.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [1:0] {
        SRC_BMOV  = 2'd0,
        SRC_FETCH = 2'd1,
        SRC_TABLE = 2'd2,
        SRC_RSVD  = 2'd3
    } ld_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } dbc_state_e;

endpackage

// File: rtl/dbc_load_sel.sv
module dbc_load_sel
    import dbc_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 32
) (
    input  logic              ld_valid,
    input  logic [1:0]        ld_src,
    input  logic [WORD_W-1:0] insn_word,
    input  logic [CNT_W-1:0]  offset_in,
    input  logic              tgt_mode,
    input  logic              cmd_phase,
    output logic              ld_take,
    output logic              ld_arm,
    output logic [CNT_W-1:0]  ld_val,
    output logic              ld_zero_err
);

    ld_src_e src_e;
    logic    exempt;

    assign src_e  = ld_src_e'(ld_src);
    assign exempt = tgt_mode && cmd_phase;

    always_comb begin
        ld_take = 1'b0;
        ld_arm  = 1'b0;
        ld_val  = '0;
        unique case (src_e)
            SRC_BMOV: begin
                ld_take = ld_valid;
                ld_arm  = ld_valid;
                ld_val  = insn_word[CNT_W-1:0];
            end
            SRC_FETCH: begin
                ld_take = ld_valid;
                ld_val  = insn_word[CNT_W-1:0];
            end
            SRC_TABLE: begin
                ld_take = ld_valid;
                ld_val  = offset_in;
            end
            SRC_RSVD: begin
                ld_take = 1'b0;
            end
        endcase
    end

    assign ld_zero_err = ld_arm && (ld_val == '0) && !exempt;

endmodule

// File: rtl/dbc_step.sv
module dbc_step #(
    parameter int CNT_W  = 24,
    parameter int XFER_W = 4
) (
    input  logic              dir_send,
    input  logic              fill_vld,
    input  logic [XFER_W-1:0] fill_bytes,
    input  logic              wr_vld,
    input  logic [XFER_W-1:0] wr_bytes,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              stb,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              over,
    output logic              hits_zero
);

    localparam int PAD_W = CNT_W - XFER_W;

    logic [XFER_W-1:0] bytes;
    logic [CNT_W-1:0]  amount;

    always_comb begin
        stb    = dir_send ? fill_vld   : wr_vld;
        bytes  = dir_send ? fill_bytes : wr_bytes;
        amount = {{PAD_W{1'b0}}, bytes};
        over   = amount > cur_cnt;
        nxt_cnt = over ? '0 : (cur_cnt - amount);
        hits_zero = (nxt_cnt == '0);
    end

endmodule

// File: rtl/dma_bytecnt.sv
module dma_bytecnt
    import dbc_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 32,
    parameter int XFER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [CNT_W-1:0]  host_wdata,
    input  logic              ld_valid,
    input  logic [1:0]        ld_src,
    input  logic [WORD_W-1:0] insn_word,
    input  logic [CNT_W-1:0]  offset_in,
    input  logic              dir_send,
    input  logic              fill_vld,
    input  logic [XFER_W-1:0] fill_bytes,
    input  logic              wr_vld,
    input  logic [XFER_W-1:0] wr_bytes,
    input  logic              tgt_mode,
    input  logic              cmd_phase,
    output logic [CNT_W-1:0]  count,
    output logic              done,
    output logic              illegal_irq,
    output logic              overrun
);

    dbc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             irq_q, irq_d, ovr_q, ovr_d;

    logic             ld_take, ld_arm, ld_zero_err;
    logic [CNT_W-1:0] ld_val;
    logic             stb, over, hits_zero;
    logic [CNT_W-1:0] nxt_cnt;

    dbc_load_sel #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_load (
        .ld_valid    (ld_valid),
        .ld_src      (ld_src),
        .insn_word   (insn_word),
        .offset_in   (offset_in),
        .tgt_mode    (tgt_mode),
        .cmd_phase   (cmd_phase),
        .ld_take     (ld_take),
        .ld_arm      (ld_arm),
        .ld_val      (ld_val),
        .ld_zero_err (ld_zero_err)
    );

    dbc_step #(.CNT_W(CNT_W), .XFER_W(XFER_W)) u_step (
        .dir_send   (dir_send),
        .fill_vld   (fill_vld),
        .fill_bytes (fill_bytes),
        .wr_vld     (wr_vld),
        .wr_bytes   (wr_bytes),
        .cur_cnt    (cnt_q),
        .stb        (stb),
        .nxt_cnt    (nxt_cnt),
        .over       (over),
        .hits_zero  (hits_zero)
    );

    // Next-state: host write > load > transfer strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        irq_d   = 1'b0;
        ovr_d   = 1'b0;
        if (host_we) begin                               // T_WRITE
            cnt_d   = host_wdata;
            state_d = (host_wdata == '0) ? ST_DONE : ST_COUNT;
        end else if (ld_take) begin
            cnt_d = ld_val;
            irq_d = ld_zero_err;
            if (ld_arm)                                  // T_ARM
                state_d = (ld_val == '0) ? ST_DONE : ST_COUNT;
            else                                         // T_HOLD
                state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (stb) begin
                        cnt_d = nxt_cnt;                 // T_STEP
                        ovr_d = over;                    // T_OVERRUN
                        if (hits_zero)
                            state_d = ST_DONE;           // T_EXHAUST
                    end
                end
                ST_IDLE, ST_DONE: begin
                    state_d = state_q;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
            ovr_q   <= ovr_d;
        end
    end

    // Count has no reset value
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // Outputs
    always_comb begin
        count       = cnt_q;
        done        = (state_q == ST_DONE);
        illegal_irq = irq_q;
        overrun     = ovr_q;
    end

    // Assertions
    p_write_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_we) |-> (count == $past(host_wdata)));

    p_done_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == '0));

    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !host_we && !ld_valid) |=> (done && $stable(count)));

    p_irq_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_irq |-> (done && count == '0));

    p_irq_exempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_irq |-> !$past(tgt_mode && cmd_phase));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !host_we && !ld_valid) |=> $stable(count));

    p_ovr_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (done && count == '0));

endmodule

// File: tb/dma_bytecnt_tb.sv
module dma_bytecnt_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [23:0] host_wdata = '0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_src = '0;
    logic [31:0] insn_word = '0;
    logic [23:0] offset_in = '0;
    logic        dir_send = 1'b0;
    logic        fill_vld = 1'b0;
    logic [3:0]  fill_bytes = '0;
    logic        wr_vld = 1'b0;
    logic [3:0]  wr_bytes = '0;
    logic        tgt_mode = 1'b0;
    logic        cmd_phase = 1'b0;
    logic [23:0] count;
    logic        done, illegal_irq, overrun;

    dma_bytecnt u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .ld_valid(ld_valid), .ld_src(ld_src), .insn_word(insn_word),
        .offset_in(offset_in), .dir_send(dir_send), .fill_vld(fill_vld),
        .fill_bytes(fill_bytes), .wr_vld(wr_vld), .wr_bytes(wr_bytes),
        .tgt_mode(tgt_mode), .cmd_phase(cmd_phase), .count(count),
        .done(done), .illegal_irq(illegal_irq), .overrun(overrun)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [23:0] cnt;
        logic        cnt_known;
        logic        dn;
        logic        irq;
        logic        ovr;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    // reference model: 0 idle, 1 counting, 2 done
    int          m_st = 0;
    logic [23:0] m_cnt = '0;
    logic        m_known = 0;

    task automatic drive(input logic we, input logic [23:0] wd,
                         input logic lv, input logic [1:0] src,
                         input logic [31:0] iw, input logic [23:0] off,
                         input logic send, input logic fv, input logic [3:0] fb,
                         input logic wv, input logic [3:0] wb,
                         input logic tgt, input logic cph, input string req);
        exp_t e;
        logic [3:0] b;
        logic s;
        host_we = we; host_wdata = wd; ld_valid = lv; ld_src = src;
        insn_word = iw; offset_in = off; dir_send = send;
        fill_vld = fv; fill_bytes = fb; wr_vld = wv; wr_bytes = wb;
        tgt_mode = tgt; cmd_phase = cph;
        e.irq = 0; e.ovr = 0;
        if (we) begin
            m_cnt = wd; m_known = 1; m_st = (wd == 0) ? 2 : 1;
        end else if (lv && src != 2'd3) begin
            m_known = 1;
            if (src == 2'd0) begin
                m_cnt = iw[23:0];
                if (m_cnt == 0) begin m_st = 2; e.irq = !(tgt && cph); end
                else m_st = 1;
            end else begin
                m_cnt = (src == 2'd1) ? iw[23:0] : off;
                m_st = 0;
            end
        end else if (m_st == 1) begin
            s = send ? fv : wv;
            b = send ? fb : wb;
            if (s) begin
                if (24'(b) > m_cnt) begin m_cnt = 0; e.ovr = 1; m_st = 2; end
                else begin m_cnt = m_cnt - 24'(b); if (m_cnt == 0) m_st = 2; end
            end
        end
        e.cnt = m_cnt; e.cnt_known = m_known; e.dn = (m_st == 2); e.req = req;
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        host_we = 0; ld_valid = 0; fill_vld = 0; wr_vld = 0;
    endtask

    // idle cycle: no stimulus
    task automatic idle(input string req);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ((e.cnt_known && count !== e.cnt) || done !== e.dn ||
                illegal_irq !== e.irq || overrun !== e.ovr) begin
                fails++;
                $display("FAIL %s: got cnt=%h done=%b irq=%b ovr=%b exp cnt=%h done=%b irq=%b ovr=%b",
                         e.req, count, done, illegal_irq, overrun,
                         e.cnt, e.dn, e.irq, e.ovr);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (done !== 0 || illegal_irq !== 0 || overrun !== 0) begin
            fails++;
            $display("FAIL R8: got done=%b irq=%b ovr=%b exp 0 0 0", done, illegal_irq, overrun);
        end
        rst_n = 1;
        @(negedge clk);
        // R8: strobes before any load do nothing visible
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd5, 0, 0, 0, 0, "R8");

        // R2: block move load 100, upper bits ignored
        drive(0, 0, 1, 2'd0, 32'hFF00_0064, 0, 1, 0, 0, 0, 0, 0, 0, "R2");
        // R3: send direction, fill counts 8, write strobe ignored
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd8, 1, 4'd5, 0, 0, "R3");
        // R3: receive direction, write counts 4, fill ignored
        drive(0, 0, 0, 0, 0, 0, 0, 1, 4'd7, 1, 4'd4, 0, 0, "R3");
        // R2: load beats strobe in same cycle
        drive(0, 0, 1, 2'd0, 32'd20, 0, 1, 1, 4'd9, 0, 0, 0, 0, "R2");
        // R4: drain exactly 15 then 5
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd15, 0, 0, 0, 0, "R4");
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd5, 0, 0, 0, 0, "R4 R7 exact");
        // R4: strobes ignored while done
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0, "R4");
        idle("R4");

        // R5: zero block move, not exempt
        drive(0, 0, 1, 2'd0, 32'h0100_0000, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
        idle("R5 pulse");
        // R5: target mode only, still raises
        drive(0, 0, 1, 2'd0, 32'd0, 0, 1, 0, 0, 0, 0, 1, 0, "R5");
        // R5: exempt target and command phase
        drive(0, 0, 1, 2'd0, 32'd0, 0, 1, 0, 0, 0, 0, 1, 1, "R5 exempt");
        idle("R5");

        // R7: overrun
        drive(0, 0, 1, 2'd0, 32'd3, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd7, 0, 0, 0, 0, "R7");
        idle("R7 pulse");

        // R2: maximum count
        drive(0, 0, 1, 2'd0, 32'h00FF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R2 max");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd15, 0, 0, "R2 R3");

        // R1: host write beats load and strobe
        drive(1, 24'h123456, 1, 2'd0, 32'd9, 0, 1, 1, 4'd2, 0, 0, 0, 0, "R1");
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd6, 0, 0, 0, 0, "R1 armed");
        drive(1, 24'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 zero");

        // R6: fetch, table, reserved
        drive(0, 0, 1, 2'd1, 32'hABCD_EF12, 0, 1, 0, 0, 0, 0, 0, 0, "R6 fetch");
        drive(0, 0, 0, 0, 0, 0, 1, 1, 4'd4, 0, 0, 0, 0, "R6 idle");
        drive(0, 0, 1, 2'd2, 32'h1111_1111, 24'h00_0ABC, 0, 0, 0, 0, 0, 0, 0, "R6 table");
        drive(0, 0, 1, 2'd3, 32'h0000_0055, 24'h00_0777, 0, 0, 0, 1, 4'd2, 0, 0, "R6 reserved");
        drive(0, 0, 1, 2'd1, 32'hFF00_0000, 0, 1, 0, 0, 0, 0, 0, 0, "R6 fetch zero");
        idle("R6");

        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule